// File: doc/BRIEF.md
# Interlocked Glitch-Free Clock Source Selector

This block produces a base clock from one of two running inputs. One is an oscillator clock and the other is a clock that comes from a phase-locked loop. A switch between the two never produces a runt pulse. The gate of the clock that is handing over is closed on its own falling edge. The gate of the incoming clock opens on its falling edge only after the incoming domain has seen, through a synchronizer, that the old gate is closed. While neither gate is open, the base clock holds a steady level. The gated clock then goes through a toggle stage, which gives a 50% duty cycle at half the input rate. When the oscillator is the active source, a configuration strap can bypass that stage.

A small control register lives in the oscillator domain. It holds a loop-enable bit and a source-select bit, and it refuses any write that would leave the two in an unsafe combination. The block also takes three divider fields from outside. A zero loop-multiplier field disables the loop and forces the oscillator. A zero reference-divider or feedback-divider field is passed on as the value one. A status output reports which source is actually driving the output.

Top module: `clksel_top`

## Requirements
- R1: While `rst_n` is low and right after it rises, `rd_pll_on`=0, `rd_sel_pll`=0 and `rd_src_pll`=0. The base clock runs from the oscillator during reset.
- R2: Without the bypass, `base_clk` runs at half the frequency of the active source. With a 5 ns oscillator this gives a 10 ns period, and with a 6 ns loop clock it gives a 12 ns period.
- R3: If `cfg_div_bypass` is high at reset, `base_clk` equals the oscillator clock (5 ns period) while the oscillator is active. While the loop clock is active, the bypass has no effect and the period stays 12 ns.
- R4: A write with `wr_sel_pll`=1 that would set the select bit is ignored while the enable bit is 0. The select bit is never 1 while the enable bit is 0.
- R5: A write that would clear the enable bit is ignored while the select bit is 1.
- R6: A single write that would change both the enable bit and the select bit is ignored as a whole.
- R7: When `mult_field`=0, `pll_run` is 0 and a write that would set the select bit is ignored. If the loop clock was active, the output returns to the oscillator (`rd_src_pll` falls).
- R8: `eff_ref_div` and `eff_fb_div` equal their input fields, except that a zero field gives the value 1.
- R9: After an accepted select change, `rd_src_pll` reaches the new value within 60 ns. The two clock gates are never open at once, and `base_clk` never has a high or low phase shorter than 2.4 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; also clocks the control register |
| pll_clk | input | 1 | Loop-derived clock |
| rst_n | input | 1 | Synchronous active-low reset, oscillator domain |
| cfg_div_bypass | input | 1 | Strap sampled during reset: skip the toggle stage for the oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_pll_on | input | 1 | Written value of the loop-enable bit |
| wr_sel_pll | input | 1 | Written value of the select bit (1 = loop clock) |
| mult_field | input | MULT_W | Loop multiplier field |
| ref_field | input | REFD_W | Reference divider field |
| fb_field | input | FBD_W | Feedback divider field |
| rd_pll_on | output | 1 | Stored loop-enable bit |
| rd_sel_pll | output | 1 | Stored select bit |
| rd_src_pll | output | 1 | 1 when the loop clock is driving the output |
| pll_run | output | 1 | Enable sent to the loop |
| eff_ref_div | output | REFD_W | Reference divider with zero mapped to one |
| eff_fb_div | output | FBD_W | Feedback divider with zero mapped to one |
| base_clk | output | 1 | Glitch-free base clock |

## Verification
The assertions check on every cycle that the two gates are never open together and that the select bit is never set without the enable bit. They also check that no accepted write changes both bits, that the enable bit cannot drop while the loop clock is selected, that select never rises while the multiplier is zero, and that the status bit only rises once the oscillator gate has closed. Some properties can only be shown by the bench scenarios: the output frequencies, the bypass behaviour for each source, the time a switch takes, and the absence of short pulses on `base_clk` across the handovers. The bench measures these at the ports.

// File: rtl/clksel_pkg.sv
// Shared definitions for the clock source selector.
// Assumes: nothing beyond IEEE 1800-2017.
package clksel_pkg;
    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } src_e;

    // Map a zero divider value onto one.
    function automatic logic [31:0] nz_or_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction
endpackage

// File: rtl/clksel_sync.sv
// Multi-stage synchronizer for WIDTH independent single-bit signals.
// Assumes: each bit is quasi-static relative to clk; rst_n is synchronous to clk.
module clksel_sync #(
    parameter int          WIDTH  = 1,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_gate.sv
// One side of the glitch-free handover. It opens its clock gate only when
// its own select is seen and the other side's gate is seen closed, and it
// changes the gate on the falling edge so that a high phase is never cut.
// Assumes: rst_n is synchronous to clk; the inputs ending in _a are asynchronous.
module clksel_gate #(
    parameter int   STAGES  = 2,
    parameter logic GATE_RST = 1'b0,
    parameter logic SEL_RST  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic my_sel_a,
    input  logic other_gate_a,
    output logic gate_q,
    output logic other_seen
);
    logic [1:0] sync_q;
    logic       sel_seen;
    logic       want;

    clksel_sync #(
        .WIDTH   (2),
        .STAGES  (STAGES),
        .RST_VAL ({SEL_RST, ~GATE_RST})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({my_sel_a, other_gate_a}),
        .q     (sync_q)
    );

    assign sel_seen   = sync_q[1];
    assign other_seen = sync_q[0];
    assign want       = sel_seen & ~other_seen;

    // Update the gate on the low phase so that the clock it passes stays whole.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= GATE_RST;
        else        gate_q <= want;
    end
endmodule

// File: rtl/clksel_ctrl.sv
// Control register in the oscillator domain. It keeps the loop-enable and
// select bits, refuses writes that would leave them unsafe, and works out
// the effective select and the loop run enable.
// Assumes: the wr_* inputs and mult_field are synchronous to clk.
module clksel_ctrl #(
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_pll_on,
    input  logic              wr_sel_pll,
    input  logic [MULT_W-1:0] mult_field,
    output logic              on_q,
    output logic              sel_q,
    output logic              sel_eff,
    output logic              pll_run
);
    logic mult_zero;
    logic chg_on, chg_sel;
    logic bad_both, bad_sel, bad_off, accept;

    // Decode the write against the current state.
    always_comb begin
        mult_zero = (mult_field == '0);
        chg_on    = (wr_pll_on  != on_q);
        chg_sel   = (wr_sel_pll != sel_q);
        bad_both  = chg_on & chg_sel;
        bad_sel   = chg_sel & wr_sel_pll & (~on_q | mult_zero);
        bad_off   = chg_on & ~wr_pll_on & sel_q;
        accept    = wr_en & ~(bad_both | bad_sel | bad_off);
    end

    // Store the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= 1'b0;
            sel_q <= 1'b0;
        end else if (accept) begin
            on_q  <= wr_pll_on;
            sel_q <= wr_sel_pll;
        end
    end

    assign pll_run = on_q & ~mult_zero;
    assign sel_eff = sel_q & pll_run;

    assert_sel_needs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> on_q);
    assert_no_dual_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q != $past(on_q)) |-> (sel_q == $past(sel_q)));
    assert_off_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && on_q) |=> on_q);
    assert_mult_zero_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> $past(mult_field) != '0);
endmodule

// File: rtl/clksel_div.sv
// Toggle stage that halves the gated clock and evens out its duty cycle.
// Assumes: the gated clock runs from the oscillator while rst_n is low.
module clksel_div (
    input  logic gclk,
    input  logic rst_n,
    output logic div_q
);
    // Toggle on every rising edge of the gated clock.
    always_ff @(posedge gclk) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= ~div_q;
    end
endmodule

// File: rtl/clksel_top.sv
// Glitch-free selector between an oscillator and a loop clock, with a
// write-interlocked control register and an optional divider bypass for the
// oscillator.
// Assumes: both clocks are running during reset; rst_n is synchronous to osc_clk.
module clksel_top
    import clksel_pkg::*;
#(
    parameter int MULT_W = 4,
    parameter int REFD_W = 4,
    parameter int FBD_W  = 8,
    parameter int STAGES = 2
) (
    input  logic              osc_clk,
    input  logic              pll_clk,
    input  logic              rst_n,
    input  logic              cfg_div_bypass,
    input  logic              wr_en,
    input  logic              wr_pll_on,
    input  logic              wr_sel_pll,
    input  logic [MULT_W-1:0] mult_field,
    input  logic [REFD_W-1:0] ref_field,
    input  logic [FBD_W-1:0]  fb_field,
    output logic              rd_pll_on,
    output logic              rd_sel_pll,
    output logic              rd_src_pll,
    output logic              pll_run,
    output logic [REFD_W-1:0] eff_ref_div,
    output logic [FBD_W-1:0]  eff_fb_div,
    output logic              base_clk
);
    logic sel_eff;
    logic pll_rst_n;
    logic osc_gate, pll_gate;
    logic osc_seen_pll, pll_seen_osc;
    logic osc_part, pll_part, gclk, div_q;
    logic bypass_q;
    src_e active_src;

    clksel_ctrl #(.MULT_W(MULT_W)) u_ctrl (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pll_on  (wr_pll_on),
        .wr_sel_pll (wr_sel_pll),
        .mult_field (mult_field),
        .on_q       (rd_pll_on),
        .sel_q      (rd_sel_pll),
        .sel_eff    (sel_eff),
        .pll_run    (pll_run)
    );

    // Reset brought into the loop-clock domain.
    clksel_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_prst (
        .clk   (pll_clk),
        .rst_n (1'b1),
        .d     (rst_n),
        .q     (pll_rst_n)
    );

    clksel_gate #(.STAGES(STAGES), .GATE_RST(1'b1), .SEL_RST(1'b1)) u_osc_gate (
        .clk          (osc_clk),
        .rst_n        (rst_n),
        .my_sel_a     (~sel_eff),
        .other_gate_a (pll_gate),
        .gate_q       (osc_gate),
        .other_seen   (osc_seen_pll)
    );

    clksel_gate #(.STAGES(STAGES), .GATE_RST(1'b0), .SEL_RST(1'b0)) u_pll_gate (
        .clk          (pll_clk),
        .rst_n        (pll_rst_n),
        .my_sel_a     (sel_eff),
        .other_gate_a (osc_gate),
        .gate_q       (pll_gate),
        .other_seen   (pll_seen_osc)
    );

    // Capture the bypass strap while reset is held.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) bypass_q <= cfg_div_bypass;
    end

    assign osc_part = osc_clk & osc_gate;
    assign pll_part = pll_clk & pll_gate;
    assign gclk     = osc_part | pll_part;

    clksel_div u_div (
        .gclk  (gclk),
        .rst_n (rst_n),
        .div_q (div_q)
    );

    // The bypass uses the raw oscillator phase; the loop source always gets the halved clock.
    assign base_clk   = bypass_q ? (osc_part | (div_q & pll_gate)) : div_q;
    assign active_src = osc_seen_pll ? SRC_PLL : SRC_OSC;
    assign rd_src_pll = (active_src == SRC_PLL);

    // Divider fields with zero mapped onto one.
    generate
        if (REFD_W > 0) begin : g_ref
            assign eff_ref_div = REFD_W'(nz_or_one(32'(ref_field)));
        end
        if (FBD_W > 0) begin : g_fb
            assign eff_fb_div = FBD_W'(nz_or_one(32'(fb_field)));
        end
    endgenerate

    assert_gates_exclusive_R9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !(osc_gate && pll_gate));
    assert_status_after_close_R9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(rd_src_pll) |-> !osc_gate);
    assert_eff_nonzero_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (eff_ref_div != '0) && (eff_fb_div != '0));
    assert_pll_side_seen_R9: assert property (@(posedge pll_clk) disable iff (!pll_rst_n)
        pll_gate |-> !pll_seen_osc);
endmodule

// File: tb/clksel_top_tb.sv
`timescale 1ns/1ps
module clksel_top_tb;
    logic osc_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
    logic cfg_div_bypass = 1'b0, wr_en = 1'b0, wr_pll_on = 1'b0, wr_sel_pll = 1'b0;
    logic [3:0] mult_field = 4'd5;
    logic [3:0] ref_field = 4'd3;
    logic [7:0] fb_field = 8'd40;
    logic rd_pll_on, rd_sel_pll, rd_src_pll, pll_run, base_clk;
    logic [3:0] eff_ref_div;
    logic [7:0] eff_fb_div;

    int n_checks = 0, n_fail = 0;
    bit mon_en = 0;
    realtime last_edge = 0.0, min_w = 1000.0;

    always #2.5 osc_clk = ~osc_clk;   // 200 MHz
    always #3.0 pll_clk = ~pll_clk;

    clksel_top u_dut (
        .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
        .cfg_div_bypass(cfg_div_bypass), .wr_en(wr_en), .wr_pll_on(wr_pll_on),
        .wr_sel_pll(wr_sel_pll), .mult_field(mult_field), .ref_field(ref_field),
        .fb_field(fb_field), .rd_pll_on(rd_pll_on), .rd_sel_pll(rd_sel_pll),
        .rd_src_pll(rd_src_pll), .pll_run(pll_run), .eff_ref_div(eff_ref_div),
        .eff_fb_div(eff_fb_div), .base_clk(base_clk)
    );

    // Narrowest phase seen on the base clock.
    always @(base_clk) begin
        if (mon_en) begin
            if ($realtime - last_edge < min_w) min_w = $realtime - last_edge;
        end
        last_edge = $realtime;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_t(input realtime act, input realtime exp, input string req);
        n_checks++;
        if (act < exp - 0.05 || act > exp + 0.05) begin
            n_fail++;
            $display("FAIL %s: actual %0.2f ns expected %0.2f ns", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset(input logic byp);
        mon_en = 0;
        rst_n = 1'b0;
        cfg_div_bypass = byp;
        repeat (20) @(negedge osc_clk);
        chk(rd_pll_on == 0 && rd_sel_pll == 0 && rd_src_pll == 0, "R1 in reset",
            {rd_pll_on, rd_sel_pll, rd_src_pll}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge osc_clk);
        mon_en = 1;
    endtask

    task automatic reg_write(input logic on, input logic sel);
        @(negedge osc_clk);
        wr_en = 1'b1; wr_pll_on = on; wr_sel_pll = sel;
        @(negedge osc_clk);
        wr_en = 1'b0;
    endtask

    task automatic period(output realtime p);
        realtime t0;
        repeat (2) @(posedge base_clk);
        t0 = $realtime;
        @(posedge base_clk);
        p = $realtime - t0;
    endtask

    task automatic wait_src(input logic exp, input string req);
        realtime t0 = $realtime;
        for (int i = 0; i < 40 && rd_src_pll != exp; i++) @(negedge osc_clk);
        chk(rd_src_pll == exp, req, rd_src_pll, exp);
        chk($realtime - t0 <= 60.0, {req, " switch time"}, int'($realtime - t0), 60);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk(rd_pll_on == 0 && rd_sel_pll == 0 && rd_src_pll == 0, "R1 after reset",
            {rd_pll_on, rd_sel_pll, rd_src_pll}, 0);
    endtask

    task automatic t_osc_divided();
        realtime p;
        period(p);
        chk_t(p, 10.0, "R2 oscillator halved");
    endtask

    task automatic t_select_needs_on();
        reg_write(1'b0, 1'b1);
        chk(rd_sel_pll == 0, "R4 select while off", rd_sel_pll, 0);
        repeat (12) @(negedge osc_clk);
        chk(rd_src_pll == 0, "R4 source unchanged", rd_src_pll, 0);
    endtask

    task automatic t_dual_change_on();
        reg_write(1'b1, 1'b1);
        chk(rd_pll_on == 0 && rd_sel_pll == 0, "R6 enable+select together",
            {rd_pll_on, rd_sel_pll}, 0);
    endtask

    task automatic t_enable_and_select();
        realtime p;
        reg_write(1'b1, 1'b0);
        chk(rd_pll_on == 1 && pll_run == 1, "R4 enable accepted", {rd_pll_on, pll_run}, 3);
        reg_write(1'b1, 1'b1);
        chk(rd_sel_pll == 1, "R4 select after enable", rd_sel_pll, 1);
        wait_src(1'b1, "R9 to loop clock");
        period(p);
        chk_t(p, 12.0, "R2 loop clock halved");
    endtask

    task automatic t_disable_blocked();
        reg_write(1'b0, 1'b1);
        chk(rd_pll_on == 1, "R5 disable while selected", rd_pll_on, 1);
        chk(rd_src_pll == 1, "R5 source kept", rd_src_pll, 1);
        reg_write(1'b0, 1'b0);
        chk(rd_pll_on == 1 && rd_sel_pll == 1, "R6 disable+deselect together",
            {rd_pll_on, rd_sel_pll}, 3);
    endtask

    task automatic t_back_to_osc();
        realtime p;
        reg_write(1'b1, 1'b0);
        wait_src(1'b0, "R9 to oscillator");
        period(p);
        chk_t(p, 10.0, "R2 oscillator halved again");
    endtask

    task automatic t_mult_zero();
        reg_write(1'b1, 1'b1);
        wait_src(1'b1, "R9 loop before zero multiplier");
        @(negedge osc_clk) mult_field = 4'd0;
        @(negedge osc_clk);
        chk(pll_run == 0, "R7 run dropped", pll_run, 0);
        wait_src(1'b0, "R7 forced to oscillator");
        reg_write(1'b1, 1'b0);
        reg_write(1'b1, 1'b1);
        chk(rd_sel_pll == 0, "R7 select blocked", rd_sel_pll, 0);
        @(negedge osc_clk) mult_field = 4'd7;
        @(negedge osc_clk);
        chk(pll_run == 1, "R7 run restored", pll_run, 1);
    endtask

    task automatic t_dividers();
        ref_field = 4'd0; fb_field = 8'd0;
        #1;
        chk(eff_ref_div == 1 && eff_fb_div == 1, "R8 zero fields",
            {eff_ref_div, eff_fb_div}, 12'h101);
        ref_field = 4'd9; fb_field = 8'd200;
        #1;
        chk(eff_ref_div == 9 && eff_fb_div == 200, "R8 passthrough",
            {eff_ref_div, eff_fb_div}, {4'd9, 8'd200});
    endtask

    task automatic t_bypass();
        realtime p;
        do_reset(1'b1);
        period(p);
        chk_t(p, 5.0, "R3 oscillator bypassed");
        reg_write(1'b1, 1'b0);
        reg_write(1'b1, 1'b1);
        wait_src(1'b1, "R3 to loop clock");
        period(p);
        chk_t(p, 12.0, "R3 bypass ignored for loop clock");
        reg_write(1'b1, 1'b0);
        wait_src(1'b0, "R3 back to oscillator");
        period(p);
        chk_t(p, 5.0, "R3 bypass again");
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset_state();
        t_osc_divided();
        t_select_needs_on();
        t_dual_change_on();
        t_enable_and_select();
        t_disable_blocked();
        t_back_to_osc();
        t_mult_zero();
        t_dividers();
        t_bypass();
        chk(min_w >= 2.4, "R9 narrowest base phase (ps)", int'(min_w * 1000), 2400);
        summary();
    end
endmodule